// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block tells a flash controller when an embedded program or erase operation inside a parallel NOR flash has finished. The controller issues the command sequence itself, then pulses `start_i` with `erase_i` saying which kind of operation is running. The poller reads the status location at the configured base address. While the operation is busy, bit 6 of the status byte changes on every read, so the block reads two bytes back to back and compares that bit.

If bit 6 is equal in both reads, the operation is complete. If bit 6 differs and bit 5 of the second read is set, the flash may have stopped on an internal timeout. In that case two more reads are taken, and a matching bit 6 there still counts as success. An attempt that does not succeed is followed by a wait. The wait is longer for an erase than for a program, and its length is set in microseconds and converted to clock cycles by a parameter. After a bounded number of failed attempts, the block gives up and reports failure.

The flash bus is a simple read port. The block raises a one-cycle request, and the bus returns one data beat flagged by a valid strobe. Only one read is outstanding at a time.

Top module: `toggle_poll`

## Requirements
- R1: After reset, `done_o`, `pass_o` and `rd_req_o` are low, and no read is issued until `start_i` is seen while idle.
- R2: Every status read is issued at address `BASE_ADDR`, and each attempt starts with two reads; if bit 6 (mask 0x40) is equal in both, the run ends with `pass_o` high.
- R3: If bit 6 differs and bit 5 (mask 0x20) of the second read is set, two further reads follow; equal bit 6 in these ends the run with pass. Bit 5 of the first read of a pair has no effect.
- R4: After a failed attempt the next request is raised exactly `ERASE_US*CYC_PER_US + 1` cycles after the response cycle for an erase, or `PROG_US*CYC_PER_US + 1` cycles for a program.
- R5: After `MAX_TRIES` failed attempts, the run ends with `pass_o` low, with no wait after the last attempt.
- R6: `done_o` is a one-cycle pulse in the cycle after the final read's `rd_valid_i` cycle; `pass_o` is valid with it and held until the next start.
- R7: Each start clears the attempt count and the wait timer, so back-to-back runs each get the full attempt budget.
- R8: `rd_req_o` is high for one cycle per read, and no new request is raised before the data of the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling, sampled while idle |
| erase_i | input | 1 | 1 = erase operation, 0 = program operation, sampled with start |
| rd_req_o | output | 1 | One-cycle read request on the flash bus |
| rd_addr_o | output | ADDR_W | Read address, always the status location |
| rd_data_i | input | DATA_W | Returned status byte |
| rd_valid_i | input | 1 | Read data valid strobe |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result: 1 = operation finished, 0 = attempt budget exhausted |

## Verification
The bench builds the poller with `CYC_PER_US=2`, `ERASE_US=3`, `PROG_US=2` and `MAX_TRIES=4`. With these values the waits are six and four cycles and the full attempt budget is small. This lets the bench sweep every count of failed attempts, from none up to exhaustion. For each count it tries every choice of which failed attempts take the bit-5 recheck path, for both erase and program and for both ways of passing. For each run it computes the read count and the start-to-done cycle count arithmetically and compares them with what it observed.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DELAY = 2'd3
  } tbp_state_e;

  localparam int TOGGLE_BIT = 6;
  localparam int ABORT_BIT  = 5;
endpackage

// File: rtl/tbp_timer.sv
module tbp_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R4: a new wait is only loaded once the previous one has run out
  assert_load_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/tbp_attempts.sv
module tbp_attempts #(
  parameter int MAX = 4,
  parameter int W   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam logic [W-1:0] LAST_VAL = W'(MAX - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == LAST_VAL);

  // R5: the failed-attempt count never passes the budget
  assert_try_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(MAX));
  // R7: a start clears the count
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/toggle_poll.sv
module toggle_poll
  import tbp_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int              CYC_PER_US = 100,
  parameter int              ERASE_US   = 50,
  parameter int              PROG_US    = 25,
  parameter int              MAX_TRIES  = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              erase_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_valid_i,
  output logic              done_o,
  output logic              pass_o
);
  localparam int ERASE_CYC = ERASE_US * CYC_PER_US;
  localparam int PROG_CYC  = PROG_US * CYC_PER_US;
  localparam int MAX_CYC   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);
  localparam logic [TMR_W-1:0] ERASE_LOAD = TMR_W'(ERASE_CYC - 1);
  localparam logic [TMR_W-1:0] PROG_LOAD  = TMR_W'(PROG_CYC - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_sync1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync1_q <= 1'b0;
      rst_sync_n  <= 1'b0;
    end else begin
      rst_sync1_q <= 1'b1;
      rst_sync_n  <= rst_sync1_q;
    end
  end

  tbp_state_e state_q, state_d;
  logic [1:0] idx_q, idx_d;
  logic       first6_q, first6_d;
  logic       erase_q, erase_d;
  logic       done_q, done_d;
  logic       pass_q, pass_d;

  logic tmr_load, tmr_zero;
  logic try_clr, try_inc, try_last;
  logic [TMR_W-1:0] tmr_val;

  assign tmr_val = erase_q ? ERASE_LOAD : PROG_LOAD;

  tbp_timer #(.W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  tbp_attempts #(.MAX(MAX_TRIES), .W(TRY_W)) u_attempts (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (try_clr),
    .inc_i  (try_inc),
    .last_o (try_last)
  );

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    first6_d = first6_q;
    erase_d  = erase_q;
    done_d   = 1'b0;
    pass_d   = pass_q;
    tmr_load = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_REQ;
          idx_d   = 2'd0;
          erase_d = erase_i;
          pass_d  = 1'b0;
          try_clr = 1'b1;
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid_i) begin
          if (!idx_q[0]) begin
            first6_d = rd_data_i[TOGGLE_BIT];
            idx_d    = idx_q + 2'd1;
            state_d  = ST_REQ;
          end else if (rd_data_i[TOGGLE_BIT] == first6_q) begin
            done_d  = 1'b1;
            pass_d  = 1'b1;
            state_d = ST_IDLE;
          end else if ((idx_q == 2'd1) && rd_data_i[ABORT_BIT]) begin
            idx_d   = 2'd2;
            state_d = ST_REQ;
          end else begin
            try_inc = 1'b1;
            if (try_last) begin
              done_d  = 1'b1;
              pass_d  = 1'b0;
              state_d = ST_IDLE;
            end else begin
              tmr_load = 1'b1;
              state_d  = ST_DELAY;
            end
          end
        end
      end
      ST_DELAY: begin
        if (tmr_zero) begin
          idx_d   = 2'd0;
          state_d = ST_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= 2'd0;
      first6_q <= 1'b0;
      erase_q  <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      first6_q <= first6_d;
      erase_q  <= erase_d;
      done_q   <= done_d;
      pass_q   <= pass_d;
    end
  end

  assign rd_req_o  = (state_q == ST_REQ);
  assign rd_addr_o = BASE_ADDR;
  assign done_o    = done_q;
  assign pass_o    = pass_q;

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  // R6: completion follows a returned read by one cycle
  assert_done_after_data_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> $past(rd_valid_i));
  // R8: a request lasts one cycle
  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_req_o |=> !rd_req_o);
  // R8: no request while a read is still outstanding
  assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_WAIT && !rd_valid_i) |=> !rd_req_o);
endmodule

// File: tb/toggle_poll_tb.sv
module toggle_poll_tb;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] BASE = 12'h5A5;
  localparam int CPU = 2, EUS = 3, PUS = 2, MAXT = 4;
  localparam int NE = EUS * CPU, NP = PUS * CPU;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, erase_i = 1'b0;
  logic rd_req_o, rd_valid_i, done_o, pass_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [7:0] rd_data_i;

  always #2.5 clk = ~clk;

  toggle_poll #(.ADDR_W(ADDR_W), .DATA_W(8), .BASE_ADDR(BASE), .CYC_PER_US(CPU),
                .ERASE_US(EUS), .PROG_US(PUS), .MAX_TRIES(MAXT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .rd_valid_i(rd_valid_i), .done_o(done_o), .pass_o(pass_o));

  int tests = 0, fails = 0;
  logic [7:0] stream [32];
  int ptr;

  // flash model: one-cycle read latency, bytes from the scenario stream
  always @(posedge clk) begin
    rd_valid_i <= rd_req_o;
    if (start_i) ptr <= 0;
    else if (rd_req_o) begin
      rd_data_i <= stream[ptr];
      ptr <= ptr + 1;
    end
  end

  // monitor, sampled on the falling edge
  int cyc = 0, n_req = 0, n_done = 0, first_req = -1, done_cyc = -1, bad_addr = 0;
  logic pass_at_done;
  always @(negedge clk) begin
    if (start_i) begin
      n_req = 0; n_done = 0; first_req = -1; done_cyc = -1; bad_addr = 0;
    end
    cyc++;
    if (rd_req_o) begin
      n_req++;
      if (first_req < 0) first_req = cyc;
      if (rd_addr_o != BASE) bad_addr++;
    end
    if (done_o) begin
      n_done++;
      done_cyc = cyc;
      pass_at_done = pass_o;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // f failed attempts; dq5 bit i = attempt i takes recheck; rc = final passes via recheck
  task automatic run(input int f, input int dq5, input bit rc, input bit er);
    int n = 0, reads = 0, delays, elapsed, wt;
    bit passed;
    for (int i = 0; i < f; i++) begin
      if (dq5[i]) begin
        stream[n++] = 8'h00; stream[n++] = 8'h60;
        stream[n++] = 8'h40; stream[n++] = 8'h00;
        reads += 4;
      end else begin
        stream[n++] = 8'h60; stream[n++] = 8'h00;  // bit5 only on first read
        reads += 2;
      end
    end
    passed = (f < MAXT);
    if (passed) begin
      if (rc) begin
        stream[n++] = 8'h40; stream[n++] = 8'h20;
        stream[n++] = 8'h04; stream[n++] = 8'h04;
        reads += 4;
      end else begin
        stream[n++] = 8'h40; stream[n++] = 8'h40;
        reads += 2;
      end
    end
    delays = passed ? f : f - 1;
    @(negedge clk); #1;
    start_i = 1'b1; erase_i = er;
    @(negedge clk); #1;
    start_i = 1'b0; erase_i = ~er;  // R4: flag is sampled only with start
    wt = 0;
    while (n_done == 0 && wt < 2000) begin @(negedge clk); wt++; end
    repeat (3) @(negedge clk);
    elapsed = done_cyc - first_req;
    check("R2/R3/R5 pass result", int'(pass_at_done), int'(passed));
    check("R2/R3 read count", n_req, reads);
    check("R2 status address", bad_addr, 0);
    check("R4/R6 start-to-done cycles", elapsed, 2 * reads + delays * (er ? NE : NP));
    check("R6 single done pulse", n_done, 1);
    check("R6 pass held", int'(pass_o), int'(passed));
  endtask

  initial begin
    rd_data_i = '0;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done_o), 0);
    check("R1 pass after reset", int'(pass_o), 0);
    check("R1 no request after reset", int'(rd_req_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle without start", n_req, 0);
    // R7: runs follow each other, each must get the full budget
    for (int er = 0; er < 2; er++)
      for (int f = 0; f <= MAXT; f++)
        for (int m = 0; m < (1 << f); m++)
          for (int rc = 0; rc < 2; rc++)
            if (!(f == MAXT && rc == 1)) run(f, m, rc[0], er[0]);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule